// File: doc/BRIEF.md
# Indirect Routing-Table Register Window

This block is the bus-facing front end of an interrupt router. It exposes a table of 64-bit per-pin routing entries, plus an identity register and a version register, through only two 32-bit bus locations: a select register and a data window. Software first writes an index into the select register. Reads and writes at the window then reach whichever 32-bit register that index names. Each routing entry occupies two consecutive indices, one for its low half and one for its high half.

The table storage lives in this block. So do two notifications to the neighbouring pin-service logic. The first is a strobe when an entry's mask bit flips. The second is a service request when software rewrites an entry whose pin is pending. The service logic can set an entry's remote-IRR status bit through a side port. A software write to the entry's low half always clears that bit again. Interrupt delivery, pin sampling and the bus fabric sit outside this block.

Top module: `irq_route_window`

## Requirements
- R1: A write at bus offset 0x00 loads the select register, which keeps the low 8 bits of the data. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R2: Reads at any offset other than 0x00 and 0x10 return zero. Writes to such offsets change no state.
- R3: With select 0x01, the window reads the pin count minus one in bits 23:16 and the version code (default 0x11) in bits 7:0. All other bits read zero. Writes with select 0x01 have no effect.
- R4: With select 0x00, the window reads and writes a 4-bit identity value in bits 27:24, and all other bits read zero. Select 0x02 reads the same value in the same position, and writes with select 0x02 are ignored.
- R5: A select value S of 0x10 or above addresses routing entry (S-0x10)>>1. An even S reaches entry bits 31:0 and an odd S reaches bits 63:32. A window write replaces that half, and a window read returns it.
- R6: When the entry index is at or beyond the pin count, window writes are discarded and window reads return zero. Select values 0x03 to 0x0F behave the same way.
- R7: Entry bit 14 is the remote-IRR status bit. A pulse on rirr_set sets it in entry rirr_idx. A low-half write stores 0 in that bit whatever the data holds. A high-half write leaves it unchanged.
- R8: Entry bit 16 is the mask bit. When a low-half write changes it, mask_chg_vld is high for one cycle after the write, carrying the entry index and the new mask value. A write that leaves the mask bit unchanged gives no pulse.
- R9: Every accepted entry write, to either half, whose pin has pin_pending set gives a one-cycle svc_req pulse after the write, with svc_idx set to that entry. Without pending there is no pulse.
- R10: After reset, every entry holds only the mask bit set (low half 0x00010000, high half 0). The select register and the identity value are zero.
- R11: Writes whose byte length bus_len is not 4 or 8 are rejected with no state change. Read data appears, with bus_rvalid high, in the cycle after bus_rd. Length 1 returns only bits 7:0, length 2 only bits 15:0, and any other length all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_pending | input | NPINS | Pending status per pin from the service logic |
| rirr_set | input | 1 | Set the remote-IRR bit of one entry |
| rirr_idx | input | IDX_W | Entry whose remote-IRR bit is set |
| mask_chg_vld | output | 1 | Mask bit of an entry changed |
| mask_chg_idx | output | IDX_W | Entry whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_req | output | 1 | Re-evaluate a pending pin after an entry write |
| svc_idx | output | IDX_W | Pin to re-evaluate |

## Verification
A corrupted select register sends every later window access to the wrong register, so the next window read returns data from a neighbouring entry or identity field, one cycle after bus_rd. A stale entry half or remote-IRR bit can only be seen when that half is read back, so the bench reads each half after every kind of write that touches it. Faulty mask-change or service logic shows up in the cycle right after the offending write, as a missing, extra or misaddressed strobe. A length check that leaks lets a short write alter the select value, and the next read of offset 0x00 exposes it.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int DW = 32;
  localparam int EW = 64;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] SEL_IDENT = 8'h00;
  localparam logic [7:0] SEL_VERS = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL0 = 8'h10;
  localparam int MASK_BIT = 16;
  localparam int RIRR_BIT = 14;
  localparam int IDENT_LSB = 24;
  localparam int IDENT_W = 4;
  localparam logic [EW-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irw_bus_front.sv
module irw_bus_front
  import irw_pkg::*;
(
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [3:0]    bus_len,
  output logic          sel_we,
  output logic          win_we,
  output logic          sel_re,
  output logic          win_re,
  output logic [DW-1:0] rd_bmask
);
  logic len_ok;

  always_comb begin
    len_ok = (bus_len == 4'd4) || (bus_len == 4'd8);
    sel_we = bus_wr && len_ok && (bus_addr == OFS_SEL);
    win_we = bus_wr && len_ok && (bus_addr == OFS_WIN);
    sel_re = bus_rd && (bus_addr == OFS_SEL);
    win_re = bus_rd && (bus_addr == OFS_WIN);
    case (bus_len)
      4'd1:    rd_bmask = 32'h0000_00FF;
      4'd2:    rd_bmask = 32'h0000_FFFF;
      default: rd_bmask = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/irw_table.sv
module irw_table
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             hi,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_word,
  input  logic [NPINS-1:0] pin_pending,
  input  logic             rirr_set,
  input  logic [IDX_W-1:0] rirr_idx,
  output logic             mask_chg_vld,
  output logic [IDX_W-1:0] mask_chg_idx,
  output logic             mask_chg_val,
  output logic             svc_req,
  output logic [IDX_W-1:0] svc_idx
);
  logic [EW-1:0] ent_q [NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ENTRY_RST;
      mask_chg_vld <= 1'b0;
      mask_chg_idx <= '0;
      mask_chg_val <= 1'b0;
      svc_req      <= 1'b0;
      svc_idx      <= '0;
    end else begin
      mask_chg_vld <= 1'b0;
      svc_req      <= 1'b0;
      if (rirr_set && (32'(rirr_idx) < NPINS))
        ent_q[rirr_idx][RIRR_BIT] <= 1'b1;
      if (we) begin
        if (hi) begin
          ent_q[idx][EW-1:DW] <= wdata;
        end else begin
          ent_q[idx][DW-1:0] <= {wdata[DW-1:RIRR_BIT+1], 1'b0, wdata[RIRR_BIT-1:0]};
          if (wdata[MASK_BIT] != ent_q[idx][MASK_BIT]) begin
            mask_chg_vld <= 1'b1;
            mask_chg_idx <= idx;
            mask_chg_val <= wdata[MASK_BIT];
          end
        end
        svc_req <= pin_pending[idx];
        svc_idx <= idx;
      end
    end
  end

  assign rd_word = hi ? ent_q[idx][EW-1:DW] : ent_q[idx][DW-1:0];

  assert_rirr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (we && !hi) |=> !ent_q[$past(idx)][RIRR_BIT]);
  assert_mask_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    mask_chg_vld |-> (ent_q[mask_chg_idx][MASK_BIT] == mask_chg_val));
  assert_svc_cause_R9: assert property (@(posedge clk) disable iff (rst)
    svc_req |-> $past(we));
  assert_reset_mask_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ent_q[0][MASK_BIT] && ent_q[NPINS-1][MASK_BIT]));
endmodule

// File: rtl/irw_rd_stage.sv
module irw_rd_stage
  import irw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] bmask,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= word & bmask;
    end
  end

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en));
endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION_ID = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [3:0]       bus_len,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pin_pending,
  input  logic             rirr_set,
  input  logic [IDX_W-1:0] rirr_idx,
  output logic             mask_chg_vld,
  output logic [IDX_W-1:0] mask_chg_idx,
  output logic             mask_chg_val,
  output logic             svc_req,
  output logic [IDX_W-1:0] svc_idx
);
  localparam int SEL_W = 8;

  logic               sel_we, win_we, sel_re, win_re;
  logic [DW-1:0]      rd_bmask;
  logic [SEL_W-1:0]   sel_q;
  logic [IDENT_W-1:0] ident_q;
  logic [SEL_W-1:0]   tsel;
  logic [SEL_W-2:0]   tidx_full;
  logic               is_tbl, tidx_ok, thi;
  logic [IDX_W-1:0]   tidx;
  logic [DW-1:0]      tbl_word, win_word, rd_word;

  irw_bus_front u_front (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_len(bus_len),
    .sel_we(sel_we), .win_we(win_we), .sel_re(sel_re), .win_re(win_re),
    .rd_bmask(rd_bmask)
  );

  // Select decode: entry index and half
  always_comb begin
    tsel      = sel_q - SEL_TBL0;
    tidx_full = tsel[SEL_W-1:1];
    thi       = tsel[0];
    is_tbl    = sel_q >= SEL_TBL0;
    tidx_ok   = is_tbl && (32'(tidx_full) < NPINS);
    tidx      = tidx_full[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (sel_we) sel_q <= bus_wdata[SEL_W-1:0];
      if (win_we && sel_q == SEL_IDENT)
        ident_q <= bus_wdata[IDENT_LSB +: IDENT_W];
    end
  end

  irw_table #(.NPINS(NPINS)) u_table (
    .clk(clk), .rst(rst),
    .we(win_we && tidx_ok), .idx(tidx), .hi(thi), .wdata(bus_wdata),
    .rd_word(tbl_word), .pin_pending(pin_pending),
    .rirr_set(rirr_set), .rirr_idx(rirr_idx),
    .mask_chg_vld(mask_chg_vld), .mask_chg_idx(mask_chg_idx),
    .mask_chg_val(mask_chg_val), .svc_req(svc_req), .svc_idx(svc_idx)
  );

  always_comb begin
    case (sel_q)
      SEL_IDENT, SEL_ARB: win_word = DW'(ident_q) << IDENT_LSB;
      SEL_VERS:           win_word = {8'h00, 8'(NPINS - 1), 8'h00, VERSION_ID};
      default:            win_word = tidx_ok ? tbl_word : '0;
    endcase
    if (sel_re)      rd_word = DW'(sel_q);
    else if (win_re) rd_word = win_word;
    else             rd_word = '0;
  end

  irw_rd_stage u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .word(rd_word), .bmask(rd_bmask),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assert_short_write_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_len != 4'd4 && bus_len != 4'd8) |=> ($stable(sel_q) && $stable(ident_q)));
  assert_arb_readonly_R4: assert property (@(posedge clk) disable iff (rst)
    (win_we && sel_q == SEL_ARB) |=> $stable(ident_q));
  assert_stray_offset_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != OFS_SEL && bus_addr != OFS_WIN) |=> $stable(sel_q));
endmodule

// File: tb/irq_route_window_tb.sv
module irq_route_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 24;
  localparam int IDX_W = $clog2(NPINS);
  localparam logic [1:0] OW = 2'd0;
  localparam logic [1:0] OR = 2'd1;
  localparam int NV = 52;

  // {req[3:0], op[1:0], addr[7:0], len[3:0], data[31:0], expect[31:0]}
  localparam logic [81:0] VEC [NV] = '{
    {4'd1,  OW, 8'h00, 4'd4, 32'h00000123, 32'h0},          // R1 upper bits dropped
    {4'd1,  OR, 8'h00, 4'd4, 32'h0, 32'h00000023},
    {4'd3,  OW, 8'h00, 4'd4, 32'h00000001, 32'h0},          // R3 version
    {4'd3,  OR, 8'h10, 4'd4, 32'h0, 32'h00170011},
    {4'd3,  OW, 8'h10, 4'd4, 32'hFFFFFFFF, 32'h0},
    {4'd3,  OR, 8'h10, 4'd4, 32'h0, 32'h00170011},
    {4'd11, OR, 8'h10, 4'd2, 32'h0, 32'h00000011},          // R11 short reads
    {4'd11, OR, 8'h10, 4'd1, 32'h0, 32'h00000011},
    {4'd11, OR, 8'h00, 4'd1, 32'h0, 32'h00000001},
    {4'd4,  OW, 8'h00, 4'd4, 32'h00000000, 32'h0},          // R4 identity
    {4'd4,  OW, 8'h10, 4'd4, 32'hA5000000, 32'h0},
    {4'd4,  OR, 8'h10, 4'd4, 32'h0, 32'h05000000},
    {4'd4,  OW, 8'h00, 4'd4, 32'h00000002, 32'h0},
    {4'd4,  OR, 8'h10, 4'd4, 32'h0, 32'h05000000},
    {4'd4,  OW, 8'h10, 4'd4, 32'h0F000000, 32'h0},
    {4'd4,  OR, 8'h10, 4'd4, 32'h0, 32'h05000000},
    {4'd4,  OW, 8'h00, 4'd4, 32'h00000000, 32'h0},
    {4'd4,  OR, 8'h10, 4'd4, 32'h0, 32'h05000000},
    {4'd5,  OW, 8'h00, 4'd4, 32'h00000012, 32'h0},          // R5 R7 low half
    {4'd5,  OW, 8'h10, 4'd4, 32'h000140AB, 32'h0},
    {4'd7,  OR, 8'h10, 4'd4, 32'h0, 32'h000100AB},
    {4'd5,  OW, 8'h00, 4'd4, 32'h00000013, 32'h0},          // R5 high half
    {4'd5,  OW, 8'h10, 4'd4, 32'hDE000000, 32'h0},
    {4'd5,  OR, 8'h10, 4'd4, 32'h0, 32'hDE000000},
    {4'd5,  OW, 8'h00, 4'd4, 32'h00000012, 32'h0},
    {4'd5,  OR, 8'h10, 4'd4, 32'h0, 32'h000100AB},
    {4'd5,  OW, 8'h00, 4'd4, 32'h0000003F, 32'h0},          // R5 last entry
    {4'd5,  OW, 8'h10, 4'd4, 32'hC3000000, 32'h0},
    {4'd5,  OR, 8'h10, 4'd4, 32'h0, 32'hC3000000},
    {4'd6,  OW, 8'h00, 4'd4, 32'h00000040, 32'h0},          // R6 index 24
    {4'd6,  OW, 8'h10, 4'd4, 32'h12345678, 32'h0},
    {4'd6,  OR, 8'h10, 4'd4, 32'h0, 32'h00000000},
    {4'd6,  OW, 8'h00, 4'd4, 32'h0000003F, 32'h0},
    {4'd6,  OR, 8'h10, 4'd4, 32'h0, 32'hC3000000},
    {4'd6,  OW, 8'h00, 4'd4, 32'h00000005, 32'h0},          // R6 gap select
    {4'd6,  OW, 8'h10, 4'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6,  OR, 8'h10, 4'd4, 32'h0, 32'h00000000},
    {4'd2,  OR, 8'h20, 4'd4, 32'h0, 32'h00000000},          // R2 stray offsets
    {4'd2,  OW, 8'h20, 4'd4, 32'h00000077, 32'h0},
    {4'd2,  OW, 8'h04, 4'd4, 32'h00000066, 32'h0},
    {4'd2,  OR, 8'h00, 4'd4, 32'h0, 32'h00000005},
    {4'd2,  OR, 8'h04, 4'd4, 32'h0, 32'h00000000},
    {4'd11, OW, 8'h00, 4'd2, 32'h00000011, 32'h0},          // R11 rejected writes
    {4'd11, OR, 8'h00, 4'd4, 32'h0, 32'h00000005},
    {4'd11, OW, 8'h00, 4'd1, 32'h00000022, 32'h0},
    {4'd11, OR, 8'h00, 4'd4, 32'h0, 32'h00000005},
    {4'd11, OW, 8'h00, 4'd4, 32'h00000012, 32'h0},
    {4'd11, OW, 8'h10, 4'd2, 32'h00000000, 32'h0},
    {4'd11, OR, 8'h10, 4'd4, 32'h0, 32'h000100AB},
    {4'd11, OW, 8'h00, 4'd8, 32'h00000030, 32'h0},
    {4'd11, OR, 8'h00, 4'd4, 32'h0, 32'h00000030},
    {4'd6,  OR, 8'h10, 4'd4, 32'h0, 32'h00010000}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [3:0]       bus_len = 4'd4;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic [NPINS-1:0] pin_pending = '0;
  logic             rirr_set = 1'b0;
  logic [IDX_W-1:0] rirr_idx = '0;
  logic             mask_chg_vld, mask_chg_val, svc_req;
  logic [IDX_W-1:0] mask_chg_idx, svc_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_window #(.NPINS(NPINS)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_pending(pin_pending), .rirr_set(rirr_set), .rirr_idx(rirr_idx),
    .mask_chg_vld(mask_chg_vld), .mask_chg_idx(mask_chg_idx),
    .mask_chg_val(mask_chg_val), .svc_req(svc_req), .svc_idx(svc_idx)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] l, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_len = l; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] l, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_len = l;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(8'h00, 4'd4, r); chk("R10 select after reset", r, 32'h0);
    chk("R11 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    chk("R11 rvalid drops", {31'b0, bus_rvalid}, 32'h0);
    rd(8'h10, 4'd4, r); chk("R10 identity after reset", r, 32'h0);
    wr(8'h00, 4'd4, 32'h1A);
    rd(8'h10, 4'd4, r); chk("R10 entry5 low", r, 32'h00010000);
    wr(8'h00, 4'd4, 32'h1B);
    rd(8'h10, 4'd4, r); chk("R10 entry5 high", r, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      if (v[77:76] == OW) wr(v[75:68], v[67:64], v[63:32]);
      else begin
        rd(v[75:68], v[67:64], r);
        chk($sformatf("R%0d vector %0d", v[81:78], i), r, v[31:0]);
      end
    end

    // R8 mask-change strobe on entry 2
    wr(8'h00, 4'd4, 32'h14);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h00000031;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 strobe on unmask", {31'b0, mask_chg_vld}, 32'h1);
    chk("R8 strobe index", 32'(mask_chg_idx), 32'd2);
    chk("R8 strobe value", {31'b0, mask_chg_val}, 32'h0);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'b0, mask_chg_vld}, 32'h0);
    wr(8'h10, 4'd4, 32'h00000032);
    chk("R8 no strobe when unchanged", {31'b0, mask_chg_vld}, 32'h0);
    wr(8'h10, 4'd4, 32'h00010032);
    chk("R8 strobe on mask", {31'b0, mask_chg_vld}, 32'h1);
    chk("R8 strobe value masked", {31'b0, mask_chg_val}, 32'h1);

    // R9 service request
    pin_pending = 24'h000004;
    wr(8'h00, 4'd4, 32'h15);
    chk("R9 no request for select write", {31'b0, svc_req}, 32'h0);
    wr(8'h10, 4'd4, 32'h11000000);
    chk("R9 request on pending write", {31'b0, svc_req}, 32'h1);
    chk("R9 request index", 32'(svc_idx), 32'd2);
    pin_pending = '0;
    wr(8'h10, 4'd4, 32'h22000000);
    chk("R9 no request without pending", {31'b0, svc_req}, 32'h0);

    // R7 remote-IRR bit
    @(negedge clk);
    rirr_set = 1'b1; rirr_idx = 5'd2;
    @(negedge clk);
    rirr_set = 1'b0;
    wr(8'h00, 4'd4, 32'h14);
    rd(8'h10, 4'd4, r); chk("R7 remote IRR set", r, 32'h00014032);
    wr(8'h00, 4'd4, 32'h15);
    wr(8'h10, 4'd4, 32'h33000000);
    wr(8'h00, 4'd4, 32'h14);
    rd(8'h10, 4'd4, r); chk("R7 high write keeps bit", r, 32'h00014032);
    wr(8'h10, 4'd4, 32'h00014032);
    rd(8'h10, 4'd4, r); chk("R7 low write clears bit", r, 32'h00010032);

    // R10 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(8'h00, 4'd4, r); chk("R10 select cleared", r, 32'h0);
    rd(8'h10, 4'd4, r); chk("R10 identity cleared", r, 32'h0);
    wr(8'h00, 4'd4, 32'h14);
    rd(8'h10, 4'd4, r); chk("R10 entry2 low restored", r, 32'h00010000);
    wr(8'h00, 4'd4, 32'h15);
    rd(8'h10, 4'd4, r); chk("R10 entry2 high cleared", r, 32'h0);

    summary();
  end
endmodule